// File: doc/BRIEF.md
# LPC Memory Read Target

This block is the peripheral side of a nibble-serial host bus: a frame strobe plus a shared 4-bit data path. It recognises a memory read cycle, gathers the 32-bit address, lets the bus turn around for two cycles, and then takes over the data path. It reports wait states with a sync code, signals ready, returns one byte as two nibbles and hands the bus back.

Storage is a byte array indexed by the low address bits. Every byte holds a fixed, computed pattern. The read latency is set by the `WAIT_CYCLES` parameter, which may be zero. Tri-state control is split into a drive enable and a drive value, so a pad ring or a bench can build the shared wire. A new frame strobe aborts any cycle in progress at any point.

Top module: `lpc_mem_rd_target`

## Requirements
- R1: After reset, and while no cycle is active, `lad_oe_o` is 0.
- R2: A cycle begins only when `frame_ni` is low and `lad_i` is 4'b0000. While the strobe stays low, only the nibble sampled in the last low cycle counts. If that nibble is not 4'b0000, the block does not respond to the cycle.
- R3: The first nibble after the strobe rises is the cycle type. The cycle is accepted only when bits 3:2 are 2'b01 and bit 1 is 0, which means a read. Bit 0 is ignored. Any other value returns the block to idle without driving the bus.
- R4: The next eight nibbles form a 32-bit address, most significant nibble first. The returned byte depends only on address bits 7:0, and the byte at address a is (a[7:0]*29 + 0x5A) mod 256.
- R5: In the two cycles after the last address nibble, `lad_oe_o` stays 0.
- R6: The block then drives the wait code 4'b0101 for exactly `WAIT_CYCLES` cycles. The default is 2, and 0 is allowed.
- R7: Next comes the ready code 4'b0000 for one cycle. It is followed by the low data nibble and then the high data nibble, all with `lad_oe_o` at 1.
- R8: After the high nibble, the block drives 4'b1111 for one cycle. In the following cycle, `lad_oe_o` is 0.
- R9: A low `frame_ni` at any clock edge aborts the current cycle. `lad_oe_o` is 0 in the next cycle, and that edge is treated as a start field under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all fields sampled and driven on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_ni | input | 1 | Active-low frame strobe from the host |
| lad_i | input | 4 | Nibble received from the shared bus |
| lad_o | output | 4 | Nibble the target drives when enabled |
| lad_oe_o | output | 1 | Drive enable for `lad_o` |

## Verification
Two instances run side by side, one with two wait cycles and one with none. Every cycle of the response is compared with a host model, so a wait count that is off by one shifts the ready code and both data nibbles and is caught at once. Sequences of start nibbles that end in a foreign value test the last-start rule: a design that latches the first start would drive a bus it does not own. Rejected cycle types cover a write and a non-memory type, and an accepted type is sent with its reserved bit set. A mid-response abort checks that the bus is released at once and that a fresh address is then served. A design that ignored the strobe during the response would keep driving its sync code instead.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CYC, ST_ADDR, ST_TAR0, ST_TAR1,
    ST_WSYNC, ST_RSYNC, ST_DLO, ST_DHI, ST_TARB
  } tgt_state_e;

  localparam logic [3:0] NIB_START_MEM = 4'b0000;
  localparam logic [3:0] NIB_WAIT      = 4'b0101;
  localparam logic [3:0] NIB_READY     = 4'b0000;
  localparam logic [3:0] NIB_TURN      = 4'b1111;
  localparam int unsigned ADDR_NIBS    = 8;
endpackage

// File: rtl/lpc_field_decode.sv
module lpc_field_decode
  import lpc_tgt_pkg::*;
(
  input  logic [3:0] lad_i,
  output logic       is_start_o,
  output logic       is_mem_rd_o
);
  // R2: memory start code; R3: type bits 3:2 = 01, dir bit 1 = 0, bit 0 ignored
  assign is_start_o  = (lad_i == NIB_START_MEM);
  assign is_mem_rd_o = (lad_i[3:2] == 2'b01) && !lad_i[1];
endmodule

// File: rtl/lpc_byte_store.sv
module lpc_byte_store #(
  parameter int unsigned MEM_AW    = 8,
  parameter int unsigned BYTE_MULT = 29,
  parameter int unsigned BYTE_SEED = 90
) (
  input  logic [MEM_AW-1:0] addr_i,
  output logic [7:0]        data_o
);
  localparam int unsigned DEPTH = 1 << MEM_AW;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = 8'((g * BYTE_MULT + BYTE_SEED) % 256);
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/lpc_wait_timer.sv
module lpc_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(WAIT_CYCLES + 2);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q <= CW'(1));

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
endmodule

// File: rtl/lpc_mem_rd_target.sv
module lpc_mem_rd_target
  import lpc_tgt_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 2,
  parameter int unsigned MEM_AW      = 8,
  parameter int unsigned BYTE_MULT   = 29,
  parameter int unsigned BYTE_SEED   = 90
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_ni,
  input  logic [3:0] lad_i,
  output logic [3:0] lad_o,
  output logic       lad_oe_o
);
  localparam int unsigned NCW = $clog2(ADDR_NIBS);
  typedef logic [MEM_AW-1:0] mem_addr_t;

  tgt_state_e state_q, state_d;
  logic [NCW-1:0] nib_q;
  mem_addr_t      addr_q;
  logic           is_start, is_mem_rd, wait_last;
  logic [7:0]     rd_byte;

  lpc_field_decode u_dec (
    .lad_i       (lad_i),
    .is_start_o  (is_start),
    .is_mem_rd_o (is_mem_rd)
  );

  lpc_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_TAR1),
    .run_i  (state_q == ST_WSYNC),
    .last_o (wait_last)
  );

  lpc_byte_store #(
    .MEM_AW(MEM_AW), .BYTE_MULT(BYTE_MULT), .BYTE_SEED(BYTE_SEED)
  ) u_store (
    .addr_i (addr_q),
    .data_o (rd_byte)
  );

  always_comb begin
    state_d = state_q;
    if (!frame_ni) begin
      // strobe low restarts decoding; last low nibble wins
      state_d = is_start ? ST_CYC : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_CYC:   state_d = is_mem_rd ? ST_ADDR : ST_IDLE;
        ST_ADDR:  state_d = (nib_q == NCW'(ADDR_NIBS - 1)) ? ST_TAR0 : ST_ADDR;
        ST_TAR0:  state_d = ST_TAR1;
        ST_TAR1:  state_d = (WAIT_CYCLES == 0) ? ST_RSYNC : ST_WSYNC;
        ST_WSYNC: state_d = wait_last ? ST_RSYNC : ST_WSYNC;
        ST_RSYNC: state_d = ST_DLO;
        ST_DLO:   state_d = ST_DHI;
        ST_DHI:   state_d = ST_TARB;
        ST_TARB:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nib_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CYC) nib_q <= '0;
      else if (state_q == ST_ADDR) begin
        nib_q  <= nib_q + 1'b1;
        // only the low address bits index storage; upper nibbles shift out
        addr_q <= mem_addr_t'({addr_q, lad_i});
      end
    end
  end

  always_comb begin
    lad_oe_o = 1'b1;
    unique case (state_q)
      ST_WSYNC: lad_o = NIB_WAIT;
      ST_RSYNC: lad_o = NIB_READY;
      ST_DLO:   lad_o = rd_byte[3:0];
      ST_DHI:   lad_o = rd_byte[7:4];
      ST_TARB:  lad_o = NIB_TURN;
      default: begin
        lad_o    = 4'b0000;
        lad_oe_o = 1'b0;
      end
    endcase
  end

  a_r9_abort_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> !lad_oe_o);
  a_r3_reject_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CYC && frame_ni && !is_mem_rd) |=> !lad_oe_o);
  a_r7_data_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RSYNC && frame_ni) |=> (lad_oe_o && state_q == ST_DLO));
  a_r8_release_after_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TARB) |=> !lad_oe_o);
  a_r5_quiet_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && frame_ni && nib_q == NCW'(ADDR_NIBS - 1)) |=> !lad_oe_o ##1 !lad_oe_o);
endmodule

// File: tb/lpc_mem_rd_target_bench.sv
`timescale 1ns/1ps
module lpc_mem_rd_target_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [3:0] lad = 4'hF;
  logic [3:0] lad_a, lad_b;
  logic       oe_a, oe_b;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  lpc_mem_rd_target #(.WAIT_CYCLES(2)) u_lpc_mem_rd_target (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .lad_i(lad),
    .lad_o(lad_a), .lad_oe_o(oe_a));

  lpc_mem_rd_target #(.WAIT_CYCLES(0)) u_lpc_mem_rd_target_w0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .lad_i(lad),
    .lad_o(lad_b), .lad_oe_o(oe_b));

  function automatic logic [7:0] exp_byte(logic [31:0] a);
    return 8'((int'(a[7:0]) * 29 + 90) % 256);
  endfunction

  // {oe, lad} expected k cycles after the last address nibble was sampled
  function automatic logic [4:0] exp_obs(int k, int w, logic [7:0] b);
    if (k < 2)          return 5'h00;
    if (k < 2 + w)      return {1'b1, 4'b0101};
    if (k == 2 + w)     return {1'b1, 4'b0000};
    if (k == 3 + w)     return {1'b1, b[3:0]};
    if (k == 4 + w)     return {1'b1, b[7:4]};
    if (k == 5 + w)     return {1'b1, 4'b1111};
    return 5'h00;
  endfunction

  function automatic string obs_tag(int k, int w);
    if (k < 2)       return "R5";
    if (k < 2 + w)   return "R6";
    if (k <= 4 + w)  return "R7";
    return "R8";
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if ((exp[4] == 1'b0) ? (act[4] != 1'b0) : (act != exp)) begin
      n_bad++;
      $display("FAIL %s: got oe=%0b lad=%h, expected oe=%0b lad=%h",
               req, act[4], act[3:0], exp[4], exp[3:0]);
    end
  endtask

  task automatic send(logic f, logic [3:0] v);
    @(negedge clk);
    frame_n = f;
    lad     = v;
  endtask

  task automatic send_addr(logic [31:0] a);
    for (int i = 7; i >= 0; i--) send(1'b1, a[i*4 +: 4]);
  endtask

  task automatic observe_read(logic [31:0] a, string ctx);
    logic [7:0] b = exp_byte(a);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk({ctx, "/", obs_tag(k, 2)}, {oe_a, lad_a}, exp_obs(k, 2, b));
      chk({ctx, "/", obs_tag(k, 0), "/w0"}, {oe_b, lad_b}, exp_obs(k, 0, b));
      frame_n = 1'b1;
      lad     = 4'hF;
    end
  endtask

  task automatic expect_quiet(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, {oe_a, lad_a}, 5'h00);
      chk({req, "/w0"}, {oe_b, lad_b}, 5'h00);
      frame_n = 1'b1;
      lad     = 4'hF;
    end
  endtask

  task automatic t_reset;
    expect_quiet("R1", 3);
  endtask

  task automatic t_read(logic [3:0] ctype, logic [31:0] a, string ctx);
    send(1'b0, 4'b0000);
    send(1'b1, ctype);
    send_addr(a);
    observe_read(a, ctx);
  endtask

  task automatic t_reject(logic [3:0] ctype);
    send(1'b0, 4'b0000);
    send(1'b1, ctype);
    send_addr(32'h0000_0011);
    expect_quiet("R3", 12);
  endtask

  task automatic t_last_start;
    // start then foreign nibble: must stay off the bus
    send(1'b0, 4'b0000);
    send(1'b0, 4'b1110);
    send(1'b1, 4'b0100);
    send_addr(32'h0000_0022);
    expect_quiet("R2", 12);
    // foreign then start: last one wins, cycle served
    send(1'b0, 4'b1110);
    send(1'b0, 4'b0000);
    send(1'b1, 4'b0100);
    send_addr(32'h0000_0033);
    observe_read(32'h0000_0033, "R2");
  endtask

  task automatic t_abort;
    logic [7:0] b = exp_byte(32'h0000_0044);
    send(1'b0, 4'b0000);
    send(1'b1, 4'b0100);
    send_addr(32'h0000_0044);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk({"R9-pre/", obs_tag(k, 2)}, {oe_a, lad_a}, exp_obs(k, 2, b));
      chk({"R9-pre/", obs_tag(k, 0), "/w0"}, {oe_b, lad_b}, exp_obs(k, 0, b));
      frame_n = 1'b1;
      lad     = 4'hF;
    end
    frame_n = 1'b0;  // new start mid response
    lad     = 4'b0000;
    @(negedge clk);
    chk("R9", {oe_a, lad_a}, 5'h00);
    chk("R9/w0", {oe_b, lad_b}, 5'h00);
    frame_n = 1'b1;
    lad     = 4'b0100;
    send_addr(32'hABCD_EF7E);
    observe_read(32'hABCD_EF7E, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read(4'b0100, 32'h0000_0000, "R4");
    t_read(4'b0100, 32'hFFFF_FFFF, "R4");
    t_read(4'b0101, 32'h1234_5678, "R3");
    t_read(4'b0100, 32'h8000_01A9, "R4");
    t_reject(4'b0110);
    t_reject(4'b0000);
    t_reject(4'b1100);
    t_last_start();
    t_abort();
    expect_quiet("R1", 2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule